// File: doc/BRIEF.md
# Memory-Backed Fixed-Latency Delay Line

This block holds back a stream of words so that each one reaches the output a fixed, compile-time number of clock cycles after it was presented. It is the usual fix when two datapaths of unequal pipeline depth must meet in the same cycle: the shorter path is routed through this block and comes out aligned with the longer one.

The samples sit in a simple dual-port memory rather than in a register chain. A write pointer and a read pointer each step once per clock and wrap at the memory depth. The memory depth is the delay rounded up to a power of two. The read pointer trails the write pointer by one less than the delay, because the registered read port adds the final cycle.

An input qualifier bit travels alongside each word. The output qualifier stays low after reset until enough words have entered to fill the delay.

Top module: `ram_delay_line`

## Requirements
- R1: While reset is asserted, and immediately after it, `out_valid` is 0 and `out_data` is all zeros.
- R2: Once primed, `out_data` in the cycle after clock edge m equals the `in_data` sampled at edge m-DELAY+1, so every word is delayed by exactly DELAY cycles.
- R3: Once primed, `out_valid` equals the `in_valid` bit that was sampled together with the word now on `out_data`.
- R4: For the first DELAY-1 clock edges after reset is released, `out_valid` is 0 and `out_data` is all zeros, whatever the inputs carry. From edge DELAY onward the block is primed.
- R5: Gaps and toggling on `in_valid` never stall or shift the pipeline. The latency stays DELAY cycles for every word.
- R6: A DELAY below 2 is rejected when the design is elaborated.
- R7: When DELAY is not a power of two, the memory depth is the next power of two. No stored word is overwritten or read back at the wrong time.
- R8: Asserting reset in the middle of a stream clears the primed state. The fill-up of R4 then repeats from the first word after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifier carried alongside each input word |
| in_data | input | WIDTH | Input word, sampled on every rising edge |
| out_valid | output | 1 | Delayed qualifier, low until primed |
| out_data | output | WIDTH | Delayed word, zero until primed |

## Verification
On every cycle, the assertions check the following: each pointer advances by exactly one, the two pointers keep their fixed distance, the read and write addresses never coincide, and the primed flag rises only at a full count and then stays set. The bench's scenarios are needed to show the end-to-end data behaviour. These include the exact latency of each word, the qualifier carried with it, and zero outputs during fill-up. They also include the repeated fill after a mid-stream reset. All of this is shown for an exact power-of-two delay, a rounded-up delay and the minimum delay.

// File: rtl/dly_pkg.sv
package dly_pkg;

    // Address bits needed to hold a delay of n cycles (at least one bit).
    function automatic int unsigned addr_bits(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    // Memory depth: the delay rounded up to a power of two.
    function automatic int unsigned pow2_depth(input int unsigned n);
        return 1 << addr_bits(n);
    endfunction

endpackage

// File: rtl/dly_ptr_counter.sv
module dly_ptr_counter #(
    parameter int unsigned AW   = 3,
    parameter int unsigned INIT = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] ptr
);

    typedef struct packed {
        logic [AW-1:0] ptr;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d     = cnt_q;
        cnt_d.ptr = cnt_q.ptr + 1'b1;   // wraps at 2**AW
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '{ptr: AW'(INIT)};
        else        cnt_q <= cnt_d;
    end

    assign ptr = cnt_q.ptr;

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ptr == AW'($past(ptr) + 1'b1)); // R5

endmodule

// File: rtl/dly_sdp_ram.sv
module dly_sdp_ram #(
    parameter int unsigned DW    = 9,
    parameter int unsigned DEPTH = 8,
    parameter int unsigned AW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    typedef struct packed {
        logic [DW-1:0] word;
    } rd_t;

    logic [DW-1:0] mem_q [DEPTH];
    rd_t           rd_d, rd_q;

    // Write port: one word every cycle, no reset on the array.
    always_ff @(posedge clk) begin
        mem_q[waddr] <= wdata;
    end

    // Registered read port.
    always_comb begin
        rd_d      = rd_q;
        rd_d.word = mem_q[raddr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rdata = rd_q.word;

    AST_RD_NE_WR: assert property (@(posedge clk) disable iff (!rst_n)
        raddr != waddr); // R7

endmodule

// File: rtl/dly_fill_tracker.sv
module dly_fill_tracker #(
    parameter int unsigned DELAY = 5
) (
    input  logic clk,
    input  logic rst_n,
    output logic primed
);

    localparam int unsigned CW   = (DELAY <= 2) ? 1 : $clog2(DELAY);
    localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

    typedef struct packed {
        logic [CW-1:0] count;
        logic          primed;
    } fill_t;

    fill_t fill_d, fill_q;

    always_comb begin
        fill_d        = fill_q;
        if (fill_q.count != LAST) fill_d.count = fill_q.count + 1'b1;
        fill_d.primed = fill_q.primed | (fill_q.count == LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fill_q <= '0;
        else        fill_q <= fill_d;
    end

    assign primed = fill_q.primed;

    AST_PRIMED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q.primed |=> fill_q.primed); // R8

    AST_PRIME_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fill_q.primed) |-> $past(fill_q.count) == LAST); // R4

endmodule

// File: rtl/ram_delay_line.sv
module ram_delay_line #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DELAY = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_data,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_data
);

    localparam int unsigned AW      = dly_pkg::addr_bits(DELAY);
    localparam int unsigned DEPTH   = dly_pkg::pow2_depth(DELAY);
    localparam int unsigned WW      = WIDTH + 1;
    // Read trails write by DELAY-1; the registered read supplies the last cycle.
    localparam int unsigned RD_INIT = (DEPTH - (DELAY - 1)) % DEPTH;

    // R6: reject delays the pointer offset cannot represent.
    generate
        if (DELAY < 2) begin : g_bad_delay
            $error("ram_delay_line: DELAY must be at least 2");
        end
    endgenerate

    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [WW-1:0] rd_word;
    logic          primed;

    dly_ptr_counter #(.AW(AW), .INIT(0)) i_wr_cnt (
        .clk(clk), .rst_n(rst_n), .ptr(wr_ptr)
    );

    dly_ptr_counter #(.AW(AW), .INIT(RD_INIT)) i_rd_cnt (
        .clk(clk), .rst_n(rst_n), .ptr(rd_ptr)
    );

    dly_sdp_ram #(.DW(WW), .DEPTH(DEPTH), .AW(AW)) i_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .waddr (wr_ptr),
        .wdata ({in_valid, in_data}),
        .raddr (rd_ptr),
        .rdata (rd_word)
    );

    dly_fill_tracker #(.DELAY(DELAY)) i_fill (
        .clk(clk), .rst_n(rst_n), .primed(primed)
    );

    assign out_valid = primed & rd_word[WIDTH];
    assign out_data  = primed ? rd_word[WIDTH-1:0] : '0;

    AST_PTR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        AW'(wr_ptr - rd_ptr) == AW'(DELAY - 1)); // R2

endmodule

// File: tb/test_ram_delay_line.sv
`timescale 1ns/1ps
module test_ram_delay_line;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;

    logic       v5, v4, v2;
    logic [7:0] d5, d4, d2;

    int checks = 0;
    int failures = 0;
    int m = 0;
    logic [7:0] hist_d [0:1023];
    logic       hist_v [0:1023];

    always #2 clk = ~clk;

    ram_delay_line #(.WIDTH(8), .DELAY(5)) i_ram_delay_line (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(v5), .out_data(d5));
    ram_delay_line #(.WIDTH(8), .DELAY(4)) i_ram_delay_line_d4 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(v4), .out_data(d4));
    ram_delay_line #(.WIDTH(8), .DELAY(2)) i_ram_delay_line_d2 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(v2), .out_data(d2));

    task automatic expect1(input string tag, input int dly, input logic a, input logic e);
        checks++;
        if (a !== e) begin
            failures++;
            $display("FAIL %s D=%0d m=%0d valid actual=%0b expected=%0b", tag, dly, m, a, e);
        end
    endtask

    task automatic expect8(input string tag, input int dly, input logic [7:0] a, input logic [7:0] e);
        checks++;
        if (a !== e) begin
            failures++;
            $display("FAIL %s D=%0d m=%0d data actual=%0h expected=%0h", tag, dly, m, a, e);
        end
    endtask

    task automatic chk(input int dly, input logic v, input logic [7:0] d, input string tag);
        string ftag;
        string dtag;
        ftag = (tag == "R8") ? "R8" : "R4";
        dtag = (dly == 5 && tag == "R2") ? "R7" : tag;
        if (m < dly) begin
            expect1(ftag, dly, v, 1'b0);
            expect8(ftag, dly, d, 8'h00);
        end else begin
            expect8(dtag, dly, d, hist_d[m-dly]);
            expect1("R3", dly, v, hist_v[m-dly]);
        end
    endtask

    task automatic chk_all(input string tag);
        chk(5, v5, d5, tag);
        chk(4, v4, d4, tag);
        chk(2, v2, d2, tag);
    endtask

    task automatic chk_zero(input string tag);
        expect1(tag, 5, v5, 1'b0); expect8(tag, 5, d5, 8'h00);
        expect1(tag, 4, v4, 1'b0); expect8(tag, 4, d4, 8'h00);
        expect1(tag, 2, v2, 1'b0); expect8(tag, 2, d2, 8'h00);
    endtask

    task automatic drive(input int mode);
        logic [7:0] dv;
        logic       vv;
        case (mode)
            0:       begin dv = 8'(m * 3 + 1);    vv = 1'b1;          end
            1:       begin dv = 8'($urandom);     vv = ((m % 3) != 0); end
            default: begin dv = 8'(8'hA5 ^ m);    vv = m[0];           end
        endcase
        hist_d[m] = dv;
        hist_v[m] = vv;
        in_data   = dv;
        in_valid  = vv;
    endtask

    task automatic step(input int mode, input string tag);
        @(posedge clk);
        #1;
        m++;
        chk_all(tag);
        drive(mode);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk_zero("R1");
        m = 0;
        drive(0);
        rst_n = 1'b1;
        repeat (60) step(0, "R2");
        repeat (80) step(1, "R5");
        @(posedge clk);
        #1;
        rst_n = 1'b0;
        #1;
        chk_zero("R1");
        repeat (2) @(posedge clk);
        #1;
        chk_zero("R8");
        m = 0;
        drive(2);
        rst_n = 1'b1;
        repeat (40) step(2, "R8");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400us;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule